// File: doc/BRIEF.md
# Dual-die register and buffer steering

This block joins one host memory-mapped port to groups of two identical die-side ports, so that each group looks like a single device with one address range. Every host access is classified by its word offset into one of three regions: boot RAM, data buffer RAM or the register file. The block then sends the die strobes that region calls for.

- Boot RAM traffic always goes to the first die of a group.
- Buffer traffic follows a per-group bank-select bit. The block captures that bit from host writes to a designated select register.
- Register writes reach both dies in the same cycle.
- Register reads follow the bank-select bit.

A second layer puts several such groups behind active-low group selects. Each group keeps its own bank-select state and its own register image.

The die ports are simple synchronous SRAM-like ports. The address and write data are shared by all dies, and the write strobe and read strobe are separate for each die. Read data is expected one cycle after the read strobe. The host request is a valid-only stream: the block never applies back-pressure and accepts one access in every cycle that `host_valid` is high. A read response appears on `host_rvalid`/`host_rdata` exactly one cycle after the access. The host must take the response in that cycle, because there is no response ready.

Top module: `dual_die_steer`

## Requirements
- R1: An access with an offset in 0x0000..0x01FF (boot region) strobes only die 0 of the selected group, whatever that group's bank-select bit holds.
- R2: An access with an offset in 0x0200..0x7FFF (buffer region) strobes only the die of the selected group whose index equals that group's bank-select bit. The strobe is the write strobe for a write and the read strobe for a read.
- R3: A write with an offset in 0xF000..0xFFFF (register region) raises the write strobe of both dies of the selected group in the same cycle, regardless of the bank-select bit.
- R4: A read in the register region raises the read strobe of only the die chosen by the bank-select bit, and returns that die's data.
- R5: The bank-select bit of a group resets to 0. A register-region write to offset 0xF101 loads it from bit 15 of the write data, at the edge that ends the write, so the very next access uses the new value.
- R6: A read at any offset outside the three regions returns 0 with `host_rvalid`, and strobes no die. A write there strobes no die and changes no state.
- R7: A read with exactly one group selected raises `host_rvalid` in the following cycle only. `host_rdata` then carries the read data the strobed die returned. Writes never raise `host_rvalid`.
- R8: An access with more than one group select low strobes no die and raises `host_err` for exactly the following cycle, without `host_rvalid`.
- R9: While a group's select is high, none of its dies sees a write or read strobe. Each group's bank-select bit changes only through writes made while that group is the only one selected.
- R10: After reset, with no access presented, `host_rvalid`, `host_err` and every die strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | NGRP (2) | Active-low group selects, bit g picks group g |
| host_valid | input | 1 | Access present this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW (16) | Word offset |
| host_wdata | input | DW (16) | Write data |
| host_rvalid | output | 1 | Read response valid, one cycle after the read |
| host_rdata | output | DW (16) | Read response data |
| host_err | output | 1 | One-cycle pulse after a conflicting-select access |
| die_addr | output | AW (16) | Address shared by all dies |
| die_wdata | output | DW (16) | Write data shared by all dies |
| die_we | output | 2*NGRP (4) | Write strobe per die, die index = 2*group + die |
| die_re | output | 2*NGRP (4) | Read strobe per die |
| die_rdata | input | 2*NGRP*DW (64) | Read data per die, valid one cycle after its read strobe |

## Verification
The bench builds the block with its default of two groups and 16-bit addresses and data, which gives four dies. With this setting the conflicting-select case and the check that group 0 and group 1 keep separate bank-select state can both be reached. Mixing random region offsets with random select patterns and writes to 0xF101 flips each group's bank-select bit many times. This exercises buffer and register-read steering to both dies, as well as the boot and register-write cases that must ignore the bit.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_BOOT = 2'd1,
    RGN_BUF  = 2'd2,
    RGN_REG  = 2'd3
  } region_e;
endpackage

// File: rtl/dds_decode.sv
module dds_decode #(
  parameter int AW        = 16,
  parameter int BOOT_LAST = 'h01FF,
  parameter int BUF_LAST  = 'h7FFF,
  parameter int REG_FIRST = 'hF000
) (
  input  logic [AW-1:0]     addr,
  output dds_pkg::region_e  region
);
  localparam logic [AW-1:0] BootLast = AW'(BOOT_LAST);
  localparam logic [AW-1:0] BufLast  = AW'(BUF_LAST);
  localparam logic [AW-1:0] RegFirst = AW'(REG_FIRST);

  always_comb begin
    if (addr <= BootLast)      region = dds_pkg::RGN_BOOT;
    else if (addr <= BufLast)  region = dds_pkg::RGN_BUF;
    else if (addr >= RegFirst) region = dds_pkg::RGN_REG;
    else                       region = dds_pkg::RGN_NONE;
  end
endmodule

// File: rtl/dds_group.sv
module dds_group #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SEL_OFF = 'hF101,
  parameter int SEL_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              we,
  input  dds_pkg::region_e  region,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [1:0]        die_we,
  output logic [1:0]        die_re
);
  localparam logic [AW-1:0] SelOff = AW'(SEL_OFF);

  logic bank_q;
  logic [1:0] bank_oh;

  assign bank_oh = bank_q ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else if (go && we && region == dds_pkg::RGN_REG && addr == SelOff)
      bank_q <= wdata[SEL_BIT];
  end

  always_comb begin
    die_we = 2'b00;
    die_re = 2'b00;
    if (go) begin
      unique case (region)
        dds_pkg::RGN_BOOT: if (we) die_we = 2'b01; else die_re = 2'b01;
        dds_pkg::RGN_BUF:  if (we) die_we = bank_oh; else die_re = bank_oh;
        dds_pkg::RGN_REG:  if (we) die_we = 2'b11; else die_re = bank_oh;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dds_resp.sv
module dds_resp #(
  parameter int NDIE = 4,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_ok,
  input  logic               conflict_acc,
  input  logic [NDIE-1:0]    die_re,
  input  logic [NDIE*DW-1:0] die_rdata,
  output logic               host_rvalid,
  output logic [DW-1:0]      host_rdata,
  output logic               host_err
);
  localparam int IW = (NDIE > 1) ? $clog2(NDIE) : 1;

  logic [IW-1:0] idx_d, idx_q;
  logic          hit_q;

  always_comb begin
    idx_d = '0;
    for (int i = 0; i < NDIE; i++)
      if (die_re[i]) idx_d = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_err    <= 1'b0;
      hit_q       <= 1'b0;
      idx_q       <= '0;
    end else begin
      host_rvalid <= rd_ok;
      host_err    <= conflict_acc;
      hit_q       <= |die_re;
      idx_q       <= idx_d;
    end
  end

  assign host_rdata = (host_rvalid && hit_q) ? die_rdata[idx_q*DW +: DW] : '0;
endmodule

// File: rtl/dual_die_steer.sv
module dual_die_steer #(
  parameter int NGRP      = 2,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BOOT_LAST = 'h01FF,
  parameter int BUF_LAST  = 'h7FFF,
  parameter int REG_FIRST = 'hF000,
  parameter int SEL_OFF   = 'hF101,
  parameter int SEL_BIT   = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NGRP-1:0]        host_sel_n,
  input  logic                   host_valid,
  input  logic                   host_we,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  output logic                   host_rvalid,
  output logic [DW-1:0]          host_rdata,
  output logic                   host_err,
  output logic [AW-1:0]          die_addr,
  output logic [DW-1:0]          die_wdata,
  output logic [2*NGRP-1:0]      die_we,
  output logic [2*NGRP-1:0]      die_re,
  input  logic [2*NGRP*DW-1:0]   die_rdata
);
  localparam int NDIE = 2 * NGRP;
  localparam int CW   = $clog2(NGRP + 1);

  dds_pkg::region_e region;
  logic [CW-1:0]    n_active;
  logic             single, conflict;

  dds_decode #(.AW(AW), .BOOT_LAST(BOOT_LAST), .BUF_LAST(BUF_LAST),
               .REG_FIRST(REG_FIRST)) u_decode (
    .addr(host_addr), .region(region));

  always_comb begin
    n_active = '0;
    for (int g = 0; g < NGRP; g++) n_active = n_active + CW'(!host_sel_n[g]);
  end

  assign single   = (n_active == CW'(1));
  assign conflict = (n_active > CW'(1));

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      dds_group #(.AW(AW), .DW(DW), .SEL_OFF(SEL_OFF), .SEL_BIT(SEL_BIT)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .go(host_valid && single && !host_sel_n[g]),
        .we(host_we), .region(region), .addr(host_addr), .wdata(host_wdata),
        .die_we(die_we[2*g +: 2]), .die_re(die_re[2*g +: 2]));
    end
  endgenerate

  assign die_addr  = host_addr;
  assign die_wdata = host_wdata;

  dds_resp #(.NDIE(NDIE), .DW(DW)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .rd_ok(host_valid && !host_we && single),
    .conflict_acc(host_valid && conflict),
    .die_re(die_re), .die_rdata(die_rdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err));
endmodule

// File: rtl/dds_chk.sv
module dds_chk #(
  parameter int NGRP      = 2,
  parameter int AW        = 16,
  parameter int BOOT_LAST = 'h01FF,
  parameter int BUF_LAST  = 'h7FFF,
  parameter int REG_FIRST = 'hF000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NGRP-1:0]   host_sel_n,
  input logic              host_valid,
  input logic              host_we,
  input logic [AW-1:0]     host_addr,
  input logic              host_rvalid,
  input logic              host_err,
  input logic [2*NGRP-1:0] die_we,
  input logic [2*NGRP-1:0] die_re
);
  logic is_boot, is_reg, is_none, one_sel, many_sel, odd_strobe;

  always_comb begin
    int n;
    n = 0;
    odd_strobe = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      n = n + (host_sel_n[g] ? 0 : 1);
      odd_strobe = odd_strobe | die_we[2*g+1] | die_re[2*g+1];
    end
    one_sel  = (n == 1);
    many_sel = (n > 1);
  end

  assign is_boot = host_addr <= AW'(BOOT_LAST);
  assign is_reg  = host_addr >= AW'(REG_FIRST);
  assign is_none = !is_boot && !is_reg && host_addr > AW'(BUF_LAST);

  assert_boot_die0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && is_boot |-> !odd_strobe);

  assert_one_reader_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(die_re));

  assert_unmapped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && is_none |-> die_we == '0 && die_re == '0);

  assert_rvalid_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_we && one_sel |=> host_rvalid);

  assert_write_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_we |=> !host_rvalid);

  assert_conflict_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && many_sel |=> host_err && !host_rvalid);

  assert_conflict_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    many_sel |-> die_we == '0 && die_re == '0);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |-> die_we == '0 && die_re == '0);

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_chk
      assert_reg_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_we && is_reg && one_sel && !host_sel_n[g]
        |-> die_we[2*g] && die_we[2*g+1]);

      assert_sel_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel_n[g] |-> die_we[2*g +: 2] == 2'b00 && die_re[2*g +: 2] == 2'b00);
    end
  endgenerate
endmodule

bind dual_die_steer dds_chk #(
  .NGRP(NGRP), .AW(AW), .BOOT_LAST(BOOT_LAST), .BUF_LAST(BUF_LAST),
  .REG_FIRST(REG_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_valid(host_valid),
  .host_we(host_we), .host_addr(host_addr), .host_rvalid(host_rvalid),
  .host_err(host_err), .die_we(die_we), .die_re(die_re));

// File: tb/dual_die_steer_tb.sv
`timescale 1ns/1ps
module dual_die_steer_tb;
  localparam int NGRP = 2;
  localparam int NDIE = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int MW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NGRP-1:0] host_sel_n = '1;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rvalid, host_err;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] die_addr;
  logic [DW-1:0] die_wdata;
  logic [NDIE-1:0] die_we, die_re;
  logic [NDIE*DW-1:0] die_rdata;

  int checks = 0, failures = 0;
  logic [DW-1:0] dmem [NDIE][1<<MW];
  logic [DW-1:0] emem [NDIE][1<<MW];
  logic ebank [NGRP];

  always #2.5 clk = ~clk;

  dual_die_steer u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_valid(host_valid),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err),
    .die_addr(die_addr), .die_wdata(die_wdata), .die_we(die_we), .die_re(die_re),
    .die_rdata(die_rdata));

  genvar d;
  generate
    for (d = 0; d < NDIE; d++) begin : g_die
      logic [DW-1:0] rd_q;
      always @(posedge clk) begin
        if (die_we[d]) dmem[d][die_addr[MW-1:0]] <= die_wdata;
        if (die_re[d]) rd_q <= dmem[d][die_addr[MW-1:0]];
      end
      assign die_rdata[d*DW +: DW] = rd_q;
    end
  endgenerate

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int region_of(input logic [AW-1:0] a);
    if (a < 16'h0200) return 1;
    if (a < 16'h8000) return 2;
    if (a >= 16'hF000) return 3;
    return 0;
  endfunction

  function automatic string tag_of(input int rg, input logic we);
    case (rg)
      1: return "R1";
      2: return "R2";
      3: return we ? "R3" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic access(input logic [NGRP-1:0] seln, input logic we,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int nact, grp, rg, die;
    logic [NDIE-1:0] ewe, ere;
    logic exp_rv, exp_err;
    logic [DW-1:0] exp_rd;
    string tg;
    nact = 0; grp = 0;
    for (int g = 0; g < NGRP; g++) if (!seln[g]) begin nact++; grp = g; end
    rg = region_of(a);
    tg = tag_of(rg, we);
    ewe = '0; ere = '0; exp_rd = '0; die = 0;
    if (nact == 1) begin
      case (rg)
        1: die = 2*grp;
        2, 3: die = 2*grp + int'(ebank[grp]);
        default: die = -1;
      endcase
      if (die >= 0) begin
        if (we && rg == 3) begin ewe[2*grp] = 1'b1; ewe[2*grp+1] = 1'b1; end
        else if (we) ewe[die] = 1'b1;
        else begin ere[die] = 1'b1; exp_rd = emem[die][a[MW-1:0]]; end
      end
    end
    if (nact > 1) tg = "R8";
    else if (nact == 0) tg = "R9";
    exp_rv  = (nact == 1) && !we;
    exp_err = (nact > 1);
    @(negedge clk);
    host_sel_n = seln; host_we = we; host_addr = a; host_wdata = wd; host_valid = 1'b1;
    #1;
    check({tg, " write strobes"}, 64'(die_we), 64'(ewe));
    check({tg, " read strobes"}, 64'(die_re), 64'(ere));
    for (int i = 0; i < NDIE; i++) if (ewe[i]) emem[i][a[MW-1:0]] = wd;
    if (nact == 1 && we && rg == 3 && a == 16'hF101) ebank[grp] = wd[15];
    @(negedge clk);
    host_valid = 1'b0;
    #1;
    check({tg, " R7 rvalid"}, 64'(host_rvalid), 64'(exp_rv));
    check({tg, " err"}, 64'(host_err), 64'(exp_err));
    if (exp_rv) check({tg, " R7 rdata"}, 64'(host_rdata), 64'(exp_rd));
  endtask

  function automatic logic [AW-1:0] pick_addr(input int k);
    case (k % 5)
      0: return AW'($urandom_range(0, 16'h01FF));
      1: return AW'($urandom_range(16'h0200, 16'h7FFF));
      2: return AW'($urandom_range(16'hF000, 16'hFFFF));
      3: return 16'hF101;
      default: return AW'($urandom_range(16'h8000, 16'hEFFF));
    endcase
  endfunction

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NDIE; i++)
      for (int j = 0; j < (1<<MW); j++) begin
        dmem[i][j] = DW'(i * 4096 + j);
        emem[i][j] = DW'(i * 4096 + j);
      end
    for (int g = 0; g < NGRP; g++) ebank[g] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 rvalid", 64'(host_rvalid), 64'd0);
    check("R10 err", 64'(host_err), 64'd0);
    check("R10 strobes", 64'({die_we, die_re}), 64'd0);

    // R5: bank starts at 0, buffer read hits die 0
    access(2'b10, 1'b0, 16'h0300, '0);
    access(2'b10, 1'b1, 16'hF101, 16'h8000);   // group 0 bank -> 1 (R5)
    access(2'b10, 1'b0, 16'h0300, '0);         // now die 1 (R5)
    access(2'b10, 1'b0, 16'h0010, '0);         // R1 boot still die 0
    access(2'b01, 1'b0, 16'h0300, '0);         // R9 group 1 unaffected
    access(2'b10, 1'b1, 16'hF200, 16'hABCD);   // R3 broadcast
    access(2'b10, 1'b0, 16'hF200, '0);         // R4 from die 1
    access(2'b10, 1'b1, 16'h9000, 16'h1111);   // R6 write ignored
    access(2'b10, 1'b0, 16'h9000, '0);         // R6 reads 0
    access(2'b00, 1'b1, 16'h0300, 16'h2222);   // R8 conflict
    access(2'b10, 1'b0, 16'h0300, '0);         // R8 no write happened
    access(2'b11, 1'b1, 16'h0300, 16'h3333);   // R9 no select
    access(2'b10, 1'b1, 16'hF101, 16'h7FFF);   // R5 bank back to 0

    for (int k = 0; k < 400; k++) begin
      logic [NGRP-1:0] s;
      int r;
      r = $urandom_range(0, 9);
      s = (r < 4) ? 2'b10 : (r < 8) ? 2'b01 : (r == 8) ? 2'b00 : 2'b11;
      access(s, 1'($urandom_range(0, 1)), pick_addr($urandom_range(0, 99)),
             DW'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule